// File: doc/BRIEF.md
# 32-bit ALU with Status Flags and Condition Gating

The block is the data-processing stage of a 32-bit integer datapath. Each cycle with `in_valid` high it takes two operands, a 4-bit operation code, a 4-bit condition code, a set-flags control and the carry-out of an external shifter. It produces a result, a write-enable for the destination register, and it maintains the N, Z, C, V status flags. Reverse subtracts, carry-using subtracts, bit-clear, move and move-inverted are supported alongside the usual add, subtract and bitwise operations. Test and compare forms update the flags and never write back.

Before any effect is allowed, a condition evaluator compares the 4-bit condition code against the flags held inside the block. A failing condition suppresses both the write and the flag update. Results appear one cycle after the operation is accepted. The flags are updated on the same edge, so the next operation sees them.

Multiplication, shifting and memory access belong to other stages. The shifter's carry-out arrives as an input.

Top module: `dp_alu_unit`

## Requirements
- R1: After reset `out_valid`, `wr_en`, `result` and `flags` (packed {N,Z,C,V}, N in bit 3, V in bit 0) are all zero.
- R2: The opcode encodings are ADD=4, ADC=5, SUB=2 and RSB=3. They give a+b, a+b+C, a-b and b-a. For these, C is the carry out of the adder, with subtracts setting C when no borrow occurs. V is signed overflow, and N and Z follow the result.
- R3: SBC=6 gives a-b-NOT(C) and RSC=7 gives b-a-NOT(C), with the same C and V rules as R2.
- R4: The logical opcodes are AND=0 (a&b), EOR=1 (a^b), ORR=12 (a|b), MOV=13 (b), BIC=14 (a&~b) and MVN=15 (~b). They update only N and Z from the result. C takes `shift_carry` and V keeps its old value.
- R5: TST=8 (a&b), TEQ=9 (a^b), CMP=10 (a-b) and CMN=11 (a+b) update flags even when `set_flags` is 0, and they never assert `wr_en`. TST and TEQ follow the logical flag rules and CMP and CMN follow the arithmetic ones.
- R6: With `set_flags`=0, a non-compare operation that passes its condition writes its result and leaves the flags unchanged.
- R7: The condition codes 0 to 7 pass on Z set, Z clear, C set, C clear, N set, N clear, V set and V clear, in that order.
- R8: Condition 8 passes when C is set and Z is clear. Condition 9 passes when C is clear or Z is set.
- R9: Condition 10 passes when N==V and condition 11 when N!=V. Condition 12 passes when Z is clear and N==V. Condition 13 passes when Z is set or N!=V.
- R10: Condition 14 always passes. Condition 15 never passes.
- R11: When the condition fails, `wr_en` stays 0 and the flags do not change.
- R12: An accepted operation shows its result, `wr_en` and updated flags with `out_valid` one cycle later. Its condition is judged on the flags left by the operation before it, including one accepted in the immediately preceding cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation accepted this cycle |
| op_i | input | 4 | Operation code |
| cond_i | input | 4 | Condition code |
| set_flags_i | input | 1 | Update flags for non-compare operations |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand (already shifted) |
| shift_carry_i | input | 1 | Shifter carry-out, used as C by logical operations |
| out_valid | output | 1 | Result of the previous accepted operation is present |
| result | output | 32 | Computed value |
| wr_en | output | 1 | Destination write-enable |
| flags | output | 4 | Current {N,Z,C,V} |

## Verification
The bench targets the subtract carry convention. A design that took C as the raw borrow would invert every unsigned comparison and give the wrong result for every carry-using subtract. It drives overflow at the signed limits in both directions, so a V computed from the wrong operand signs shows up at once. It runs back-to-back operations where a compare feeds the next condition, which exposes a design that judges conditions on stale flags or that lets failed or flag-less operations leak flag updates. A long stream of random operations, with every condition code present, checks the signed and unsigned compound conditions against an independent model.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  typedef enum logic [3:0] {
    CC_ZS = 4'h0, CC_ZC = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
    CC_NS = 4'h4, CC_NC = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
    CC_UHI = 4'h8, CC_ULS = 4'h9, CC_SGE = 4'hA, CC_SLT = 4'hB,
    CC_SGT = 4'hC, CC_SLE = 4'hD, CC_ALL = 4'hE, CC_NONE = 4'hF
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
  import alu_pkg::*;
(
  input  logic [3:0] cond_i,
  input  flags_t     fl_i,
  output logic       pass_o
);

  logic sgn_ge;
  assign sgn_ge = (fl_i.n == fl_i.v);

  always_comb begin
    unique case (cond_e'(cond_i))
      CC_ZS:   pass_o = fl_i.z;
      CC_ZC:   pass_o = !fl_i.z;
      CC_CS:   pass_o = fl_i.c;
      CC_CC:   pass_o = !fl_i.c;
      CC_NS:   pass_o = fl_i.n;
      CC_NC:   pass_o = !fl_i.n;
      CC_VS:   pass_o = fl_i.v;
      CC_VC:   pass_o = !fl_i.v;
      CC_UHI:  pass_o = fl_i.c && !fl_i.z;
      CC_ULS:  pass_o = !fl_i.c || fl_i.z;
      CC_SGE:  pass_o = sgn_ge;
      CC_SLT:  pass_o = !sgn_ge;
      CC_SGT:  pass_o = !fl_i.z && sgn_ge;
      CC_SLE:  pass_o = fl_i.z || !sgn_ge;
      CC_ALL:  pass_o = 1'b1;
      default: pass_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  flags_t        fl_i,
  input  logic          shc_i,
  output logic [DW-1:0] res_o,
  output flags_t        nfl_o,
  output logic          no_wb_o,
  output logic          is_logic_o
);

  localparam int MSB = DW - 1;

  typedef struct packed {
    logic [DW-1:0] sum;
    logic          cout;
    logic          ovf;
  } add_t;

  function automatic add_t adder(input logic [DW-1:0] x, input logic [DW-1:0] y,
                                 input logic ci);
    logic [DW:0] s;
    add_t r;
    s      = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci};
    r.sum  = s[DW-1:0];
    r.cout = s[DW];
    r.ovf  = (x[MSB] == y[MSB]) && (s[MSB] != x[MSB]);
    return r;
  endfunction

  logic [DW-1:0] ax, ay, lres;
  logic          aci;
  add_t          ar;

  // operand steering: subtracts become x + ~y + carry-in
  always_comb begin
    ax  = a_i;
    ay  = b_i;
    aci = 1'b0;
    unique case (alu_op_e'(op_i))
      OP_ADC:          aci = fl_i.c;
      OP_SUB, OP_CMP:  begin ay = ~b_i; aci = 1'b1;    end
      OP_SBC:          begin ay = ~b_i; aci = fl_i.c;  end
      OP_RSB:          begin ax = b_i; ay = ~a_i; aci = 1'b1;   end
      OP_RSC:          begin ax = b_i; ay = ~a_i; aci = fl_i.c; end
      default: ;
    endcase
  end

  assign ar = adder(ax, ay, aci);

  always_comb begin
    unique case (alu_op_e'(op_i))
      OP_AND, OP_TST: lres = a_i & b_i;
      OP_EOR, OP_TEQ: lres = a_i ^ b_i;
      OP_ORR:         lres = a_i | b_i;
      OP_MOV:         lres = b_i;
      OP_BIC:         lres = a_i & ~b_i;
      OP_MVN:         lres = ~b_i;
      default:        lres = '0;
    endcase
  end

  always_comb begin
    unique case (alu_op_e'(op_i))
      OP_AND, OP_EOR, OP_TST, OP_TEQ,
      OP_ORR, OP_MOV, OP_BIC, OP_MVN: is_logic_o = 1'b1;
      default:                        is_logic_o = 1'b0;
    endcase
  end

  assign no_wb_o = (op_i[3:2] == 2'b10);
  assign res_o   = is_logic_o ? lres : ar.sum;

  always_comb begin
    nfl_o.n = res_o[MSB];
    nfl_o.z = (res_o == '0);
    nfl_o.c = is_logic_o ? shc_i  : ar.cout;
    nfl_o.v = is_logic_o ? fl_i.v : ar.ovf;
  end

endmodule

// File: rtl/dp_alu_unit.sv
module dp_alu_unit
  import alu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    op_i,
  input  logic [3:0]    cond_i,
  input  logic          set_flags_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic          shift_carry_i,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic          wr_en,
  output logic [3:0]    flags
);

  flags_t        fl_q;
  flags_t        fl_new;
  logic [DW-1:0] core_res;
  logic          no_wb, is_logic;
  logic          cond_ok;
  logic          exec_go;
  logic          flag_wr;

  alu_cond_eval u_cond (
    .cond_i (cond_i),
    .fl_i   (fl_q),
    .pass_o (cond_ok)
  );

  alu_core #(.DW(DW)) u_core (
    .op_i       (op_i),
    .a_i        (opa_i),
    .b_i        (opb_i),
    .fl_i       (fl_q),
    .shc_i      (shift_carry_i),
    .res_o      (core_res),
    .nfl_o      (fl_new),
    .no_wb_o    (no_wb),
    .is_logic_o (is_logic)
  );

  assign exec_go = in_valid && cond_ok;
  assign flag_wr = exec_go && (set_flags_i || no_wb);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fl_q      <= '0;
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= exec_go && !no_wb;
      if (in_valid) result <= core_res;
      if (flag_wr)  fl_q   <= fl_new;
    end
  end

  assign flags = fl_q;

  // R5
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_i[3:2] == 2'b10 |=> !wr_en);

  // R11
  fail_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !cond_ok |=> !wr_en && $stable(flags));

  // R10
  never_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cond_i == 4'hF |=> !wr_en);

  // R6
  hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !set_flags_i && op_i[3:2] != 2'b10 |=> $stable(flags));

  // R4
  logic_keeps_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_logic |=> flags[0] == $past(flags[0]));

  // R12
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R12
  write_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> out_valid);

endmodule

// File: tb/dp_alu_unit_tb.sv
module dp_alu_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op_i = '0, cond_i = 4'hE;
  logic        set_flags_i = 1'b0, shift_carry_i = 1'b0;
  logic [31:0] opa_i = '0, opb_i = '0;
  logic        out_valid, wr_en;
  logic [31:0] result;
  logic [3:0]  flags;

  always #5 clk = ~clk;

  dp_alu_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_i(op_i), .cond_i(cond_i),
    .set_flags_i(set_flags_i), .opa_i(opa_i), .opb_i(opb_i),
    .shift_carry_i(shift_carry_i), .out_valid(out_valid), .result(result),
    .wr_en(wr_en), .flags(flags)
  );

  typedef struct {
    logic [31:0] res;
    logic        we;
    logic [3:0]  fl;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          n_chk = 0, n_bad = 0;
  logic [3:0]  mfl = 4'h0;   // model flags {N,Z,C,V}
  bit          done = 0;

  function automatic bit cond_pass(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      0: return z;        1: return !z;
      2: return c;        3: return !c;
      4: return n;        5: return !n;
      6: return v;        7: return !v;
      8: return c & !z;   9: return !c | z;
      10: return n == v;  11: return n != v;
      12: return !z && (n == v);
      13: return z || (n != v);
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [3:0] cc, input logic sf,
                       input logic [31:0] a, input logic [31:0] b, input logic shc,
                       input string tag_ov);
    logic [31:0] r;
    logic        n, z, c, v, lg, arith_sub, cmp, ok;
    longint      lx, ly, us, ss;
    logic [31:0] x, y;
    int          k;
    exp_t        e;
    c = mfl[1]; v = mfl[0];
    lg = 0; arith_sub = 0; k = 0; x = a; y = b;
    case (op)
      0, 8:  begin lg = 1; r = a & b; end
      1, 9:  begin lg = 1; r = a ^ b; end
      12:    begin lg = 1; r = a | b; end
      13:    begin lg = 1; r = b; end
      14:    begin lg = 1; r = a & ~b; end
      15:    begin lg = 1; r = ~b; end
      4, 11: k = 0;
      5:     k = int'(mfl[1]);
      2, 10: begin arith_sub = 1; k = 0; end
      6:     begin arith_sub = 1; k = int'(!mfl[1]); end
      3:     begin arith_sub = 1; k = 0; x = b; y = a; end
      default: begin arith_sub = 1; k = int'(!mfl[1]); x = b; y = a; end
    endcase
    if (!lg) begin
      if (arith_sub) begin
        us = longint'(x) - longint'(y) - k;
        ss = longint'($signed(x)) - longint'($signed(y)) - k;
        c  = (us >= 0);
      end else begin
        us = longint'(x) + longint'(y) + k;
        ss = longint'($signed(x)) + longint'($signed(y)) + k;
        c  = (us > 64'h0_FFFF_FFFF);
      end
      r = us[31:0];
      v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
    end else begin
      c = shc;
    end
    n = r[31]; z = (r == 0);
    cmp = (op >= 8 && op <= 11);
    ok = cond_pass(cc, mfl);
    if (tag_ov != "") e.tag = tag_ov;
    else if (cc == 15) e.tag = "R10";
    else if (!ok) e.tag = "R11";
    else if (cc == 8 || cc == 9) e.tag = "R8";
    else if (cc >= 10 && cc <= 13) e.tag = "R9";
    else if (cc <= 7) e.tag = "R7";
    else if (cmp) e.tag = "R5";
    else if (!sf) e.tag = "R6";
    else if (lg) e.tag = "R4";
    else if (op == 6 || op == 7) e.tag = "R3";
    else e.tag = "R2";
    if (ok && (sf || cmp)) mfl = {n, z, c, v};
    e.res = r;
    e.we  = ok && !cmp;
    e.fl  = mfl;
    sb_q.push_back(e);
    in_valid = 1; op_i = op; cond_i = cc; set_flags_i = sf;
    opa_i = a; opb_i = b; shift_carry_i = shc;
    @(negedge clk);
    in_valid = 0;
  endtask

  // monitor: outputs are registered, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      if (sb_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R12 unexpected out_valid: actual 1 expected 0");
      end else begin
        e = sb_q.pop_front();
        check(e.tag, "result", result, e.res);
        check(e.tag, "wr_en", {31'b0, wr_en}, {31'b0, e.we});
        check(e.tag, "flags", {28'b0, flags}, {28'b0, e.fl});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "out_valid", {31'b0, out_valid}, 0);
    check("R1", "wr_en", {31'b0, wr_en}, 0);
    check("R1", "result", result, 0);
    check("R1", "flags", {28'b0, flags}, 0);
    rst_n = 1;
    @(negedge clk);
    // R2 adds and subtracts at the limits
    issue(4'h4, 4'hE, 1, 32'h7FFF_FFFF, 32'h1, 0, "R2");
    issue(4'h4, 4'hE, 1, 32'hFFFF_FFFF, 32'h1, 0, "R2");
    issue(4'h5, 4'hE, 1, 32'h10, 32'h20, 0, "R2");
    issue(4'h2, 4'hE, 1, 32'h0, 32'h1, 0, "R2");
    issue(4'h2, 4'hE, 1, 32'h8000_0000, 32'h1, 0, "R2");
    issue(4'h2, 4'hE, 1, 32'h5, 32'h5, 0, "R2");
    issue(4'h3, 4'hE, 1, 32'h3, 32'hA, 0, "R2");
    // R3 carry-using subtracts, C clear then set
    issue(4'hA, 4'hE, 0, 32'h0, 32'h1, 0, "R5");
    issue(4'h6, 4'hE, 1, 32'hA, 32'h3, 0, "R3");
    issue(4'h7, 4'hE, 1, 32'h3, 32'hA, 0, "R3");
    issue(4'h6, 4'hE, 1, 32'h8000_0000, 32'h0, 0, "R3");
    // R4 logical forms, V retained, C from shifter
    issue(4'hE, 4'hE, 1, 32'hF0F0_FFFF, 32'h00F0_000F, 1, "R4");
    issue(4'hF, 4'hE, 1, 32'h0, 32'h0, 0, "R4");
    issue(4'hD, 4'hE, 1, 32'h0, 32'h0, 1, "R4");
    // R5 compares with set_flags low
    issue(4'hB, 4'hE, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, "R5");
    issue(4'h8, 4'hE, 0, 32'hF0, 32'h0F, 1, "R5");
    issue(4'h9, 4'hE, 0, 32'h55, 32'h55, 0, "R5");
    // R6 writes without flag update
    issue(4'h4, 4'hE, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R6");
    // R12 compare result steers the very next condition
    issue(4'hA, 4'hE, 0, 32'h9, 32'h9, 0, "R12");
    issue(4'h4, 4'h0, 1, 32'h1, 32'h2, 0, "R12");
    issue(4'hA, 4'hE, 0, 32'h9, 32'h8, 0, "R12");
    issue(4'hD, 4'h0, 1, 32'h0, 32'hAB, 0, "R12");
    // R10 never
    issue(4'hA, 4'hF, 0, 32'h1, 32'h2, 0, "R10");
    // random stream covering R7 R8 R9 R11
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ra, rb, rr;
      rr = $urandom;
      ra = (rr[1:0] == 0) ? 32'h8000_0000 : $urandom;
      rb = (rr[3:2] == 0) ? ra : (rr[5:4] == 0 ? 32'h7FFF_FFFF : $urandom);
      issue(rr[11:8], rr[15:12], rr[16], ra, rb, rr[17], "");
    end
    repeat (3) @(negedge clk);
    check("R12", "queue drained", sb_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule